// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup

This block is the load lookup path of a 64 KB, 16-way set-associative data cache with 64-byte lines. A request carries a 24-bit virtual address. In the request cycle the set index is taken only from bits that lie inside the 4 KB page, so the tag and data arrays are read while a 16-entry fully associative translation buffer maps the 12-bit virtual page number to a 12-bit physical page number. Each stored tag is a physical page number with a valid bit. The block compares the stored tags with the translated page number, never with virtual bits. Because the index never uses translated bits, every virtual alias of one physical word selects the same set and finds the same line.

The result is registered and appears one cycle after the request. A small response state machine holds the outcome. It has four states: RSP_IDLE (no request in the previous cycle), RSP_HIT, RSP_MISS and RSP_TLBMISS. Each cycle the machine goes to RSP_TLBMISS when a valid request finds no translation. It goes to RSP_HIT when the translation exists and one valid way's tag matches, and to RSP_MISS when the translation exists but no way matches. With no request it returns to RSP_IDLE. Any state can reach any other state in one cycle.

Translations are written by slot through a translation fill port. A line fill port writes a tag and a full line into the way that the set's round-robin victim pointer names, then advances that pointer. Page-table walking, coherence and write-back belong to other blocks.

Top module: `vipt_cache_lookup`

## Requirements
- R1: After reset, hit, miss, tlb_miss and rd_data are 0, every line is invalid, and every set's victim pointer is 0.
- R2: The address fields are as follows: set index = req_vaddr[11:6], word select = req_vaddr[5:2], virtual page number = req_vaddr[23:12]. The outcome of a request sampled at clock edge N appears on the outputs after edge N and holds until edge N+1. A line fill at edge N is not visible to a request sampled at that same edge.
- R3: The translation buffer has 16 fully associative slots. A write to a slot replaces that slot's old mapping. A valid request whose page number matches no valid slot raises tlb_miss alone, with hit and miss low.
- R4: A valid request hits when a valid way in its set holds a physical tag equal to the translated page number. hit is then raised alone.
- R5: A valid request whose translation exists but whose set holds no matching valid tag raises miss alone.
- R6: Two virtual page numbers that translate to the same physical page return the same line and the same word.
- R7: After a valid request exactly one of hit, miss and tlb_miss is high. After a cycle with no request all three are low.
- R8: Each set keeps its own victim pointer. The first fill to a set after reset goes to way 0, the k-th fill goes to way (k-1) mod 16, and the pointer wraps after way 15, which overwrites way 0.
- R9: On a hit, rd_data is the 32-bit word fill_line[32*w +: 32] of the matching line, where w is the word select. rd_data is 0 whenever hit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 24 | Virtual byte address of the lookup |
| tlb_wr_en | input | 1 | Translation write strobe |
| tlb_wr_slot | input | 4 | Translation slot to write |
| tlb_wr_vpn | input | 12 | Virtual page number of the new mapping |
| tlb_wr_ppn | input | 12 | Physical page number of the new mapping |
| fill_en | input | 1 | Line fill strobe |
| fill_set | input | 6 | Set that receives the line |
| fill_ptag | input | 12 | Physical page number stored as the tag |
| fill_line | input | 512 | Line contents, word 0 in the low bits |
| hit | output | 1 | Previous request hit |
| miss | output | 1 | Previous request translated but missed |
| tlb_miss | output | 1 | Previous request had no translation |
| rd_data | output | 32 | Word returned on a hit, 0 otherwise |

## Verification
Assertions check the following on every cycle. At most one translation slot matches and at most one way in a set matches. The outcome flags are one-hot after a request and all low after an idle cycle. A missing translation always gives tlb_miss. Every fill advances only its own set's victim pointer by one. The bench scenarios are the only place that shows the stored tag really is the physical page number: the aliasing case, a translation remapped to a page that is not stored, and a fill that lands in the same cycle as a lookup. The scenarios are also the only check that the returned word comes from the right way and offset, and that eviction follows the round-robin order and wraps.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    localparam int VA_W        = 24;
    localparam int PAGE_BITS   = 12;
    localparam int LINE_BYTES  = 64;
    localparam int NWAYS       = 16;
    localparam int TLB_SLOTS   = 16;
    localparam int WORD_W      = 32;
    localparam int PA_PAGE_W   = 12;

    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int SET_W   = PAGE_BITS - OFF_W;
    localparam int NSETS   = 1 << SET_W;
    localparam int VPN_W   = VA_W - PAGE_BITS;
    localparam int WAY_W   = $clog2(NWAYS);
    localparam int SLOT_W  = $clog2(TLB_SLOTS);
    localparam int LINE_W  = LINE_BYTES * 8;
    localparam int WSEL_W  = $clog2(LINE_W / WORD_W);
    localparam int BYTE_W  = $clog2(WORD_W / 8);

    typedef enum logic [1:0] {
        RSP_IDLE    = 2'd0,
        RSP_HIT     = 2'd1,
        RSP_MISS    = 2'd2,
        RSP_TLBMISS = 2'd3
    } rsp_state_e;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 12,
    parameter int PPN_W   = 12,
    parameter int SLOT_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn
);
    logic [ENTRIES-1:0] slot_valid_q;
    logic [VPN_W-1:0]   slot_vpn_q [ENTRIES];
    logic [PPN_W-1:0]   slot_ppn_q [ENTRIES];
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_valid_q <= '0;
        end else if (wr_en) begin
            slot_valid_q[wr_slot] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_vpn_q[wr_slot] <= wr_vpn;
            slot_ppn_q[wr_slot] <= wr_ppn;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = slot_valid_q[g] && (slot_vpn_q[g] == lk_vpn);
    end

    always_comb begin
        lk_hit = 1'b0;
        lk_ppn = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_hit = 1'b1;
                lk_ppn = slot_ppn_q[i];
            end
        end
    end

    // R3: software keeps page numbers unique, so a lookup matches one slot at most
    a_r3_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match) <= 1)
        else $error("more than one translation slot matched");
endmodule

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
    parameter int NSETS = 64,
    parameter int NWAYS = 16,
    parameter int TAG_W = 12,
    parameter int SET_W = $clog2(NSETS),
    parameter int WAY_W = $clog2(NWAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    input  logic [TAG_W-1:0] cmp_tag,
    output logic             hit_any,
    output logic [WAY_W-1:0] hit_way,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [TAG_W-1:0] fill_tag,
    output logic [WAY_W-1:0] fill_way
);
    localparam int ENTRIES = NSETS * NWAYS;

    logic [TAG_W-1:0] tag_q    [ENTRIES];
    logic [NWAYS-1:0] valid_q  [NSETS];
    logic [WAY_W-1:0] victim_q [NSETS];
    logic [NWAYS-1:0] way_hit;

    assign fill_way = victim_q[fill_set];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) begin
                valid_q[s]  <= '0;
                victim_q[s] <= '0;
            end
        end else if (fill_en) begin
            valid_q[fill_set][fill_way] <= 1'b1;
            victim_q[fill_set]          <= fill_way + WAY_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[{fill_set, fill_way}] <= fill_tag;
        end
    end

    for (genvar g = 0; g < NWAYS; g++) begin : g_way
        assign way_hit[g] = valid_q[rd_set][g] &&
                            (tag_q[{rd_set, WAY_W'(g)}] == cmp_tag);
    end

    always_comb begin
        hit_any = 1'b0;
        hit_way = '0;
        for (int i = NWAYS - 1; i >= 0; i--) begin
            if (way_hit[i]) begin
                hit_any = 1'b1;
                hit_way = WAY_W'(i);
            end
        end
    end

    // R4: a physical page is never installed twice in one set
    a_r4_single_way: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(way_hit) <= 1)
        else $error("more than one way matched");

    // R8: a fill advances its set's pointer by exactly one step
    a_r8_pointer_step: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> victim_q[$past(fill_set)] == $past(fill_way) + WAY_W'(1))
        else $error("victim pointer did not advance");
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
    parameter int NSETS  = 64,
    parameter int NWAYS  = 16,
    parameter int LINE_W = 512,
    parameter int WORD_W = 32,
    parameter int SET_W  = $clog2(NSETS),
    parameter int WAY_W  = $clog2(NWAYS),
    parameter int WSEL_W = $clog2(LINE_W / WORD_W)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [WSEL_W-1:0] rd_wsel,
    output logic [WORD_W-1:0] rd_word
);
    localparam int ENTRIES = NSETS * NWAYS;

    logic [LINE_W-1:0] line_q [ENTRIES];
    logic [LINE_W-1:0] line_rd;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[{wr_set, wr_way}] <= wr_line;
        end
    end

    assign line_rd = line_q[{rd_set, rd_way}];
    assign rd_word = line_rd[rd_wsel * WORD_W +: WORD_W];
endmodule

// File: rtl/vipt_cache_lookup.sv
module vipt_cache_lookup
    import vipt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic                 tlb_wr_en,
    input  logic [SLOT_W-1:0]    tlb_wr_slot,
    input  logic [VPN_W-1:0]     tlb_wr_vpn,
    input  logic [PA_PAGE_W-1:0] tlb_wr_ppn,
    input  logic                 fill_en,
    input  logic [SET_W-1:0]     fill_set,
    input  logic [PA_PAGE_W-1:0] fill_ptag,
    input  logic [LINE_W-1:0]    fill_line,
    output logic                 hit,
    output logic                 miss,
    output logic                 tlb_miss,
    output logic [WORD_W-1:0]    rd_data
);
    logic [VPN_W-1:0]     req_vpn;
    logic [SET_W-1:0]     req_set;
    logic [WSEL_W-1:0]    req_wsel;
    logic                 tlb_hit;
    logic [PA_PAGE_W-1:0] tlb_ppn;
    logic                 tag_hit;
    logic [WAY_W-1:0]     tag_way;
    logic [WAY_W-1:0]     fill_way;
    logic [WORD_W-1:0]    word_rd;
    rsp_state_e           rsp_q, rsp_d;
    logic [WORD_W-1:0]    data_q;

    assign req_vpn  = req_vaddr[VA_W-1:PAGE_BITS];
    assign req_set  = req_vaddr[PAGE_BITS-1:OFF_W];
    assign req_wsel = req_vaddr[OFF_W-1:BYTE_W];

    vipt_tlb #(
        .ENTRIES(TLB_SLOTS), .VPN_W(VPN_W), .PPN_W(PA_PAGE_W), .SLOT_W(SLOT_W)
    ) u_tlb (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tlb_wr_en),
        .wr_slot(tlb_wr_slot),
        .wr_vpn (tlb_wr_vpn),
        .wr_ppn (tlb_wr_ppn),
        .lk_vpn (req_vpn),
        .lk_hit (tlb_hit),
        .lk_ppn (tlb_ppn)
    );

    vipt_tag_store #(
        .NSETS(NSETS), .NWAYS(NWAYS), .TAG_W(PA_PAGE_W), .SET_W(SET_W), .WAY_W(WAY_W)
    ) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_set  (req_set),
        .cmp_tag (tlb_ppn),
        .hit_any (tag_hit),
        .hit_way (tag_way),
        .fill_en (fill_en),
        .fill_set(fill_set),
        .fill_tag(fill_ptag),
        .fill_way(fill_way)
    );

    vipt_data_store #(
        .NSETS(NSETS), .NWAYS(NWAYS), .LINE_W(LINE_W), .WORD_W(WORD_W),
        .SET_W(SET_W), .WAY_W(WAY_W), .WSEL_W(WSEL_W)
    ) u_data (
        .clk    (clk),
        .wr_en  (fill_en),
        .wr_set (fill_set),
        .wr_way (fill_way),
        .wr_line(fill_line),
        .rd_set (req_set),
        .rd_way (tag_way),
        .rd_wsel(req_wsel),
        .rd_word(word_rd)
    );

    // next response state
    always_comb begin
        rsp_d = RSP_IDLE;
        if (req_valid) begin
            if (!tlb_hit) begin
                rsp_d = RSP_TLBMISS;
            end else if (tag_hit) begin
                rsp_d = RSP_HIT;
            end else begin
                rsp_d = RSP_MISS;
            end
        end
    end

    // state register and returned word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q  <= RSP_IDLE;
            data_q <= '0;
        end else begin
            rsp_q  <= rsp_d;
            data_q <= (rsp_d == RSP_HIT) ? word_rd : '0;
        end
    end

    // outputs decoded from the state
    always_comb begin
        hit      = 1'b0;
        miss     = 1'b0;
        tlb_miss = 1'b0;
        unique case (rsp_q)
            RSP_IDLE:    ;
            RSP_HIT:     hit      = 1'b1;
            RSP_MISS:    miss     = 1'b1;
            RSP_TLBMISS: tlb_miss = 1'b1;
            default:     ;
        endcase
    end

    assign rd_data = data_q;

    // R7: a request yields exactly one outcome flag
    a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> $onehot({hit, miss, tlb_miss}))
        else $error("outcome flags not one-hot after request");

    // R7: an idle cycle leaves all flags low
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(hit || miss || tlb_miss))
        else $error("flag raised without request");

    // R3: missing translation always reports tlb_miss
    a_r3_tlb_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !tlb_hit) |=> tlb_miss)
        else $error("translation miss not reported");

    // R9: no data outside a hit
    a_r9_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> rd_data == '0)
        else $error("data driven without hit");
endmodule

// File: tb/vipt_cache_lookup_bench.sv
module vipt_cache_lookup_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [23:0]  req_vaddr = '0;
    logic         tlb_wr_en = 1'b0;
    logic [3:0]   tlb_wr_slot = '0;
    logic [11:0]  tlb_wr_vpn = '0;
    logic [11:0]  tlb_wr_ppn = '0;
    logic         fill_en = 1'b0;
    logic [5:0]   fill_set = '0;
    logic [11:0]  fill_ptag = '0;
    logic [511:0] fill_line = '0;
    logic         hit, miss, tlb_miss;
    logic [31:0]  rd_data;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    vipt_cache_lookup u_vipt_cache_lookup (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .tlb_wr_en(tlb_wr_en), .tlb_wr_slot(tlb_wr_slot), .tlb_wr_vpn(tlb_wr_vpn),
        .tlb_wr_ppn(tlb_wr_ppn), .fill_en(fill_en), .fill_set(fill_set),
        .fill_ptag(fill_ptag), .fill_line(fill_line), .hit(hit), .miss(miss),
        .tlb_miss(tlb_miss), .rd_data(rd_data)
    );

    function automatic logic [11:0] vpn_of(input int k);
        return 12'(k * 7 + 3);
    endfunction

    function automatic logic [11:0] ppn_of(input int k);
        return 12'(k * 37 + 64);
    endfunction

    function automatic logic [31:0] word_of(input logic [11:0] tag, input int s,
                                            input int w, input int way);
        return {4'h0, tag, 2'b10, 6'(s), 4'(w), 4'(way)};
    endfunction

    function automatic logic [511:0] line_of(input logic [11:0] tag, input int s,
                                             input int way);
        logic [511:0] l;
        for (int w = 0; w < 16; w++) l[w*32 +: 32] = word_of(tag, s, w, way);
        return l;
    endfunction

    function automatic logic [23:0] va_of(input logic [11:0] vpn, input int s,
                                          input int w);
        return {vpn, 6'(s), 4'(w), 2'b00};
    endfunction

    task automatic check(input string req, input logic [34:0] act,
                         input logic [34:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got flags/data %h expected %h", req, act, exp);
        end
    endtask

    task automatic tlb_write(input int slot, input logic [11:0] vpn,
                             input logic [11:0] ppn);
        @(negedge clk);
        tlb_wr_en = 1'b1; tlb_wr_slot = 4'(slot); tlb_wr_vpn = vpn; tlb_wr_ppn = ppn;
        @(negedge clk);
        tlb_wr_en = 1'b0;
    endtask

    task automatic line_fill(input int s, input logic [11:0] tag, input int way);
        @(negedge clk);
        fill_en = 1'b1; fill_set = 6'(s); fill_ptag = tag;
        fill_line = line_of(tag, s, way);
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic lookup(input logic [23:0] va);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [34:0] outs();
        return {hit, miss, tlb_miss, rd_data};
    endfunction

    localparam logic [34:0] EXP_MISS = {3'b010, 32'h0};
    localparam logic [34:0] EXP_TLBM = {3'b001, 32'h0};

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: got cycle %0d expected under 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", outs(), 35'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 idle quiet", outs(), 35'h0);

        lookup(va_of(12'h123, 4, 1));
        check("R3 empty translation buffer", outs(), EXP_TLBM);

        for (int k = 0; k < 16; k++) tlb_write(k, vpn_of(k), ppn_of(k));
        lookup(va_of(vpn_of(0), 5, 0));
        check("R1 lines invalid after reset", outs(), EXP_MISS);

        // k-th fill of every set lands in way k (R8)
        for (int k = 0; k < 16; k++)
            for (int s = 0; s < 64; s++) line_fill(s, ppn_of(k), k);

        for (int k = 0; k < 16; k++)
            for (int s = 0; s < 64; s++) begin
                int w = (s + 3 * k) % 16;
                lookup(va_of(vpn_of(k), s, w));
                check("R4 R9 R2 sweep hit", outs(),
                      {3'b100, word_of(ppn_of(k), s, w, k)});
            end

        lookup(va_of(12'hFFF, 7, 3));
        check("R3 unknown page", outs(), EXP_TLBM);
        @(negedge clk);
        check("R7 idle after request", outs(), 35'h0);

        // alias: slot 15 remapped to another virtual page of ppn_of(3)
        tlb_write(15, 12'h800, ppn_of(3));
        lookup(va_of(12'h800, 9, 2));
        check("R6 alias hit", outs(), {3'b100, word_of(ppn_of(3), 9, 2, 3)});
        lookup(va_of(vpn_of(3), 9, 2));
        check("R6 original name same word", outs(), {3'b100, word_of(ppn_of(3), 9, 2, 3)});
        lookup(va_of(vpn_of(15), 9, 2));
        check("R3 slot overwrite drops old mapping", outs(), EXP_TLBM);

        tlb_write(14, 12'h900, 12'hABC);
        lookup(va_of(12'h900, 0, 6));
        check("R5 page not cached", outs(), EXP_MISS);

        // seventeenth fill of set 0 wraps to way 0
        line_fill(0, 12'hABC, 0);
        lookup(va_of(12'h900, 0, 6));
        check("R8 wrap fill hit", outs(), {3'b100, word_of(12'hABC, 0, 6, 0)});
        lookup(va_of(vpn_of(0), 0, 6));
        check("R8 way 0 evicted", outs(), EXP_MISS);
        lookup(va_of(vpn_of(1), 0, 6));
        check("R8 way 1 kept", outs(), {3'b100, word_of(ppn_of(1), 0, 6, 1)});
        tlb_write(13, 12'hA00, 12'hDEF);
        line_fill(0, 12'hDEF, 1);
        lookup(va_of(vpn_of(1), 0, 6));
        check("R8 way 1 evicted next", outs(), EXP_MISS);
        lookup(va_of(12'hA00, 0, 15));
        check("R8 second wrap fill", outs(), {3'b100, word_of(12'hDEF, 0, 15, 1)});
        lookup(va_of(vpn_of(2), 0, 15));
        check("R8 way 2 kept", outs(), {3'b100, word_of(ppn_of(2), 0, 15, 2)});

        // fill and lookup at the same edge: lookup sees old contents (R2)
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va_of(vpn_of(0), 20, 4);
        fill_en = 1'b1; fill_set = 6'd20; fill_ptag = 12'hDEF;
        fill_line = line_of(12'hDEF, 20, 0);
        @(negedge clk);
        req_valid = 1'b0; fill_en = 1'b0;
        check("R2 same-edge fill hidden", outs(), {3'b100, word_of(ppn_of(0), 20, 4, 0)});
        lookup(va_of(vpn_of(0), 20, 4));
        check("R2 fill visible afterwards", outs(), EXP_MISS);
        lookup(va_of(12'hA00, 20, 4));
        check("R9 new line word", outs(), {3'b100, word_of(12'hDEF, 20, 4, 0)});

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule